// File: doc/BRIEF.md
# Alpha Channel Rectangle Fill

This block sets the alpha byte of every pixel inside a rectangle of a 32-bit-per-pixel surface and leaves the colour bytes alone. A single command carries the surface's base address, its pitch, a tiled/linear flag, a pixel-size code and two packed corners. The block walks the rectangle row by row and issues one byte-masked write per pixel to a simple memory port. Only the top byte lane is enabled, so only alpha changes. The written pattern is the fill colour, all ones by default, because the fill copies the pattern straight through and ignores what the destination held before.

A typical use is to force alpha to opaque after an opaque-format surface has been copied into a surface that has an alpha channel. When the walk is finished, a one-cycle done pulse tells the caller that it may issue the next command. A command is accepted in any cycle where `cmd_valid` and `cmd_ready` are both high. Writes are handed over on a valid/ready pair.

Top module: `alpha_rect_fill`

## Requirements
- R1: Directly after reset, `cmd_ready` is 1 and both `mem_req` and `done` are 0.
- R2: Every write request carries byte strobe 4'b1000 (alpha in bits 31:24) and data equal to the fill colour 0xFFFFFFFF. Byte lanes 2..0 are never enabled.
- R3: Each corner word holds y in bits 31:16 and x in bits 15:0. The second corner is exclusive, and the number of writes equals (x2-x1)*(y2-y1).
- R4: With `cmd_tiled`=0 the pitch is in bytes, and the pixel at (x,y) is written at byte address base + y*pitch + x*4.
- R5: With `cmd_tiled`=1 the pitch field counts dwords, and the byte pitch used in the address is pitch*4.
- R6: Pixels are written in row-major order, x rising within a row and rows in rising y. With `mem_ready` held high, one pixel is written per cycle and `done` comes N+1 cycles after the accepting edge for N pixels.
- R7: While `mem_req` is 1 and `mem_ready` is 0, the request and its address stay unchanged into the next cycle.
- R8: An empty rectangle (x2<=x1 or y2<=y1) causes no write, and `done` is high in the cycle right after acceptance.
- R9: `cmd_bpp` encodes 2'b00 = 8 bpp, 2'b01 = 16 bpp (565), 2'b10 and 2'b11 = 32 bpp (8888). Only 32 bpp has an alpha byte. For the other two codes the command causes no write, and `done` follows one cycle after acceptance.
- R10: `done` is a single-cycle pulse and never coincides with `mem_req`. While a fill runs, `cmd_ready` is 0 and a command presented on the inputs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_base | input | ADDR_W | Surface base byte address |
| cmd_pitch | input | COORD_W | Pitch, in bytes if linear or in dwords if tiled |
| cmd_tiled | input | 1 | Surface is tiled |
| cmd_bpp | input | 2 | Pixel size code |
| cmd_corner0 | input | 2*COORD_W | First corner, y high half, x low half (inclusive) |
| cmd_corner1 | input | 2*COORD_W | Second corner, y high half, x low half (exclusive) |
| mem_req | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory takes the write this cycle |
| mem_addr | output | ADDR_W | Write byte address |
| mem_wdata | output | 32 | Write data |
| mem_strb | output | 4 | Byte lane enables |
| done | output | 1 | Fill finished (one cycle) |

## Verification
The assertions check, in every cycle, the alpha-only strobe and fill data, the holding of a stalled request, the single-cycle shape of `done` and its exclusion from `mem_req`, and the idle outputs after reset. Only the bench's scenarios can show that the address sequence follows the row-major order and the pitch scaling for both the linear and the tiled case. The same holds for the pixel count implied by the exclusive corners, for the one-cycle completion of empty and non-32-bit commands, and for a command offered mid-fill being dropped.

// File: rtl/arf_pkg.sv
// Shared definitions for the alpha rectangle fill block.
// Assumes: pixel size codes are 2 bits wide and only 32 bpp carries alpha.
package arf_pkg;
    typedef enum logic [1:0] {
        BPP_8    = 2'b00,
        BPP_16   = 2'b01,
        BPP_32   = 2'b10,
        BPP_32B  = 2'b11
    } bpp_code_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_e;

    localparam int unsigned PIXEL_BYTES = 4;
    localparam logic [3:0]  ALPHA_STRB  = 4'b1000;
endpackage

// File: rtl/arf_cmd_decode.sv
// Command decode: unpacks the corners, scales the pitch to bytes, flags
// commands that produce no writes, and computes the first pixel address.
// Assumes: corners pack y in the upper half and x in the lower half.
module arf_cmd_decode #(
    parameter int ADDR_W  = 32,
    parameter int COORD_W = 16,
    localparam int PB_W   = COORD_W + 2
) (
    input  logic [ADDR_W-1:0]    base,
    input  logic [COORD_W-1:0]   pitch,
    input  logic                 tiled,
    input  logic [1:0]           bpp,
    input  logic [2*COORD_W-1:0] corner0,
    input  logic [2*COORD_W-1:0] corner1,
    output logic [COORD_W-1:0]   x1,
    output logic [COORD_W-1:0]   y1,
    output logic [COORD_W-1:0]   x2,
    output logic [COORD_W-1:0]   y2,
    output logic [PB_W-1:0]      pitch_bytes,
    output logic                 no_writes,
    output logic [ADDR_W-1:0]    start_addr
);
    import arf_pkg::*;

    logic empty_rect;
    logic has_alpha;

    // Unpack corners and derive pitch, emptiness and first address.
    always_comb begin
        x1 = corner0[COORD_W-1:0];
        y1 = corner0[2*COORD_W-1:COORD_W];
        x2 = corner1[COORD_W-1:0];
        y2 = corner1[2*COORD_W-1:COORD_W];
        pitch_bytes = tiled ? {pitch, 2'b00} : {2'b00, pitch};
        empty_rect  = (x2 <= x1) || (y2 <= y1);
        has_alpha   = (bpp == BPP_32) || (bpp == BPP_32B);
        no_writes   = empty_rect || !has_alpha;
        start_addr  = base
                    + ADDR_W'(y1) * ADDR_W'(pitch_bytes)
                    + ADDR_W'(x1) * ADDR_W'(PIXEL_BYTES);
    end
endmodule

// File: rtl/arf_walker.sv
// Rectangle walker: steps x then y through the rectangle and reports the
// end of each row and the final pixel.
// Assumes: loaded only with a non-empty rectangle.
module arf_walker #(
    parameter int COORD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [COORD_W-1:0] x1,
    input  logic [COORD_W-1:0] y1,
    input  logic [COORD_W-1:0] x2,
    input  logic [COORD_W-1:0] y2,
    output logic               row_end,
    output logic               last
);
    logic [COORD_W-1:0] x_q, y_q, xs_q, xe_q, ye_q;

    // Hold the current position and the rectangle bounds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q  <= '0;
            y_q  <= '0;
            xs_q <= '0;
            xe_q <= '0;
            ye_q <= '0;
        end else if (load) begin
            x_q  <= x1;
            y_q  <= y1;
            xs_q <= x1;
            xe_q <= x2;
            ye_q <= y2;
        end else if (step) begin
            if (row_end) begin
                x_q <= xs_q;
                y_q <= y_q + 1'b1;
            end else begin
                x_q <= x_q + 1'b1;
            end
        end
    end

    // Detect the row end and the last pixel of the rectangle.
    always_comb begin
        row_end = ({1'b0, x_q} + 1'b1) == {1'b0, xe_q};
        last    = row_end && (({1'b0, y_q} + 1'b1) == {1'b0, ye_q});
    end
endmodule

// File: rtl/arf_addr_gen.sv
// Address generator: keeps the current pixel address and its row start.
// It advances by one pixel, or by one pitch at a row end.
// Assumes: the start address already includes the x and y offsets.
module arf_addr_gen #(
    parameter int ADDR_W  = 32,
    parameter int PB_W    = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              row_end,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [PB_W-1:0]   pitch_bytes,
    output logic [ADDR_W-1:0] pix_addr
);
    import arf_pkg::*;

    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] pitch_q;
    logic [ADDR_W-1:0] next_row;

    // Compute the first pixel address of the following row.
    always_comb next_row = row_q + pitch_q;

    // Track the pixel address and the row start address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q    <= '0;
            pitch_q  <= '0;
            pix_addr <= '0;
        end else if (load) begin
            row_q    <= start_addr;
            pitch_q  <= ADDR_W'(pitch_bytes);
            pix_addr <= start_addr;
        end else if (step) begin
            if (row_end) begin
                row_q    <= next_row;
                pix_addr <= next_row;
            end else begin
                pix_addr <= pix_addr + ADDR_W'(PIXEL_BYTES);
            end
        end
    end
endmodule

// File: rtl/alpha_rect_fill.sv
// Alpha rectangle fill top: takes one command, walks the rectangle and
// issues alpha-only writes. It pulses done once the last write is taken.
// Assumes: the memory port takes a write on any edge where req and ready
// are both high.
module alpha_rect_fill #(
    parameter int          ADDR_W     = 32,
    parameter int          COORD_W    = 16,
    parameter logic [31:0] FILL_COLOR = 32'hFFFF_FFFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [ADDR_W-1:0]    cmd_base,
    input  logic [COORD_W-1:0]   cmd_pitch,
    input  logic                 cmd_tiled,
    input  logic [1:0]           cmd_bpp,
    input  logic [2*COORD_W-1:0] cmd_corner0,
    input  logic [2*COORD_W-1:0] cmd_corner1,
    output logic                 mem_req,
    input  logic                 mem_ready,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [31:0]          mem_wdata,
    output logic [3:0]           mem_strb,
    output logic                 done
);
    import arf_pkg::*;

    localparam int PB_W = COORD_W + 2;

    fill_state_e        state_q;
    logic               done_q;
    logic               accept, fire, load;
    logic               row_end, last;
    logic               no_writes;
    logic [COORD_W-1:0] x1, y1, x2, y2;
    logic [PB_W-1:0]    pitch_bytes;
    logic [ADDR_W-1:0]  start_addr;

    arf_cmd_decode #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u_dec (
        .base(cmd_base), .pitch(cmd_pitch), .tiled(cmd_tiled),
        .bpp(cmd_bpp), .corner0(cmd_corner0), .corner1(cmd_corner1),
        .x1(x1), .y1(y1), .x2(x2), .y2(y2),
        .pitch_bytes(pitch_bytes), .no_writes(no_writes),
        .start_addr(start_addr)
    );

    arf_walker #(.COORD_W(COORD_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(load), .step(fire),
        .x1(x1), .y1(y1), .x2(x2), .y2(y2),
        .row_end(row_end), .last(last)
    );

    arf_addr_gen #(.ADDR_W(ADDR_W), .PB_W(PB_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .step(fire),
        .row_end(row_end), .start_addr(start_addr),
        .pitch_bytes(pitch_bytes), .pix_addr(mem_addr)
    );

    // Handshake decode for commands and memory writes.
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        accept    = cmd_valid && cmd_ready;
        load      = accept && !no_writes;
        mem_req   = (state_q == ST_RUN);
        fire      = mem_req && mem_ready;
        mem_wdata = FILL_COLOR;
        mem_strb  = ALPHA_STRB;
        done      = done_q;
    end

    // Sequence the fill and produce the one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    if (no_writes) done_q  <= 1'b1;
                    else           state_q <= ST_RUN;
                end
                ST_RUN: if (fire && last) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/arf_checker.sv
// Protocol checker for the alpha rectangle fill, bound to its top module.
// Assumes: synchronous active-low reset on rst_n.
module arf_checker #(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] FILL_COLOR = 32'hFFFF_FFFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              mem_req,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic [3:0]        mem_strb,
    input logic              done
);
    logic rst_seen_q;

    // Remember the reset level of the previous edge.
    always_ff @(posedge clk) rst_seen_q <= rst_n;

    // First cycle out of reset must show idle outputs.
    always_ff @(posedge clk) begin
        if (rst_n && (rst_seen_q == 1'b0)) begin
            assert_reset_idle_R1: assert (cmd_ready && !mem_req && !done)
                else $error("outputs not idle after reset");
        end
    end

    assert_alpha_lane_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_strb == 4'b1000) && (mem_wdata == FILL_COLOR));

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cmd_ready);
endmodule

bind alpha_rect_fill arf_checker #(.ADDR_W(ADDR_W), .FILL_COLOR(FILL_COLOR)) u_arf_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .mem_req(mem_req),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_strb(mem_strb), .done(done)
);

// File: tb/alpha_rect_fill_bench.sv
// Directed bench for alpha_rect_fill: one task per scenario.
module alpha_rect_fill_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_base = '0;
    logic [15:0] cmd_pitch = '0;
    logic        cmd_tiled = 1'b0;
    logic [1:0]  cmd_bpp = 2'b10;
    logic [31:0] cmd_corner0 = '0;
    logic [31:0] cmd_corner1 = '0;
    logic        mem_req;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_strb;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    // Monitor state
    bit          stall_mode = 1'b0;
    int          n_wr = 0;
    int          done_cnt = 0;
    int          lane_err = 0;
    int          hold_err = 0;
    bit          hold_pend = 1'b0;
    logic [31:0] hold_addr = '0;
    logic [31:0] wr_addr [0:255];
    logic [31:0] exp_addr [0:255];

    alpha_rect_fill u_alpha_rect_fill (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_base(cmd_base), .cmd_pitch(cmd_pitch), .cmd_tiled(cmd_tiled),
        .cmd_bpp(cmd_bpp), .cmd_corner0(cmd_corner0), .cmd_corner1(cmd_corner1),
        .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_strb(mem_strb), .done(done)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory-side model: drives ready and records writes at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (hold_pend && !(mem_req && mem_addr == hold_addr)) hold_err++;
            hold_pend = 1'b0;
            mem_ready = stall_mode ? ~mem_ready : 1'b1;
            if (mem_req && mem_ready) begin
                if (n_wr < 256) wr_addr[n_wr] = mem_addr;
                n_wr++;
                if (mem_strb != 4'b1000 || mem_wdata != 32'hFFFF_FFFF) lane_err++;
            end else if (mem_req) begin
                hold_pend = 1'b1;
                hold_addr = mem_addr;
            end
            if (done) done_cnt++;
        end
    end

    // Watchdog
    initial begin
        wait (cycles > 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Offer a command for one edge, then return right after that edge.
    task automatic issue(input logic [31:0] base, input logic [15:0] pitch,
                         input bit tiled, input logic [1:0] bpp,
                         input int x1, input int y1, input int x2, input int y2);
        @(negedge clk);
        #1;
        n_wr = 0; done_cnt = 0; lane_err = 0; hold_err = 0;
        cmd_base = base; cmd_pitch = pitch; cmd_tiled = tiled; cmd_bpp = bpp;
        cmd_corner0 = {y1[15:0], x1[15:0]};
        cmd_corner1 = {y2[15:0], x2[15:0]};
        cmd_valid = 1'b1;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    // Wait for done and return the number of falling edges until it was seen.
    task automatic wait_done(output int k);
        k = 0;
        while (done_cnt == 0 && k < 400) begin
            @(negedge clk);
            #1;
            k++;
        end
        repeat (3) @(negedge clk);
        #1;
    endtask

    // Build the expected address list; returns the pixel count.
    function automatic int expect_list(input logic [31:0] base, input int pb,
                                       input int x1, input int y1,
                                       input int x2, input int y2);
        int n = 0;
        for (int y = y1; y < y2; y++)
            for (int x = x1; x < x2; x++) begin
                if (n < 256) exp_addr[n] = base + y * pb + x * 4;
                n++;
            end
        return n;
    endfunction

    task automatic compare(input string req, input int n);
        int bad = 0;
        int first_bad = 0;
        check(n_wr == n, req, "write count", n_wr, n);
        for (int i = 0; i < n && i < n_wr && i < 256; i++)
            if (wr_addr[i] !== exp_addr[i]) begin
                if (bad == 0) first_bad = i;
                bad++;
            end
        check(bad == 0, req, "address sequence",
              (bad == 0) ? 0 : wr_addr[first_bad], (bad == 0) ? 0 : exp_addr[first_bad]);
        check(lane_err == 0, "R2", "alpha-only strobe/data errors", lane_err, 0);
        check(done_cnt == 1, "R10", "done pulse count", done_cnt, 1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);
        check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);
    endtask

    task automatic t_linear;
        int k, n;
        n = expect_list(32'h1000, 64, 2, 1, 5, 3);
        issue(32'h1000, 16'd64, 1'b0, 2'b10, 2, 1, 5, 3);
        wait_done(k);
        compare("R4", n);
        check(k == n + 1, "R6", "cycles to done, ready held", k, n + 1);
    endtask

    task automatic t_tiled;
        int k, n;
        n = expect_list(32'h8000, 64, 5, 3, 7, 5);
        issue(32'h8000, 16'd16, 1'b1, 2'b11, 5, 3, 7, 5);
        wait_done(k);
        compare("R5", n);
    endtask

    task automatic t_stall;
        int k, n;
        n = expect_list(32'h2000, 256, 0, 0, 4, 2);
        stall_mode = 1'b1;
        issue(32'h2000, 16'd256, 1'b0, 2'b10, 0, 0, 4, 2);
        wait_done(k);
        stall_mode = 1'b0;
        compare("R7", n);
        check(hold_err == 0, "R7", "request moved while stalled", hold_err, 0);
    endtask

    task automatic t_single;
        int k, n;
        n = expect_list(32'h0, 32, 7, 9, 8, 10);
        issue(32'h0, 16'd32, 1'b0, 2'b10, 7, 9, 8, 10);
        wait_done(k);
        compare("R3", n);
    endtask

    task automatic t_empty;
        int k;
        issue(32'h100, 16'd64, 1'b0, 2'b10, 4, 1, 4, 6);
        wait_done(k);
        check(k == 1, "R8", "done latency, x2==x1", k, 1);
        check(n_wr == 0, "R8", "writes, x2==x1", n_wr, 0);
        issue(32'h100, 16'd64, 1'b0, 2'b10, 1, 6, 3, 2);
        wait_done(k);
        check(k == 1, "R8", "done latency, y2<y1", k, 1);
        check(n_wr == 0, "R8", "writes, y2<y1", n_wr, 0);
    endtask

    task automatic t_small_bpp;
        int k;
        issue(32'h300, 16'd64, 1'b0, 2'b00, 0, 0, 3, 2);
        wait_done(k);
        check(k == 1 && n_wr == 0, "R9", "8 bpp: latency*1000+writes", k * 1000 + n_wr, 1000);
        issue(32'h300, 16'd64, 1'b0, 2'b01, 0, 0, 3, 2);
        wait_done(k);
        check(k == 1 && n_wr == 0, "R9", "16 bpp: latency*1000+writes", k * 1000 + n_wr, 1000);
    endtask

    task automatic t_busy_ignore;
        int k, n;
        n = expect_list(32'h4000, 128, 1, 1, 5, 4);
        issue(32'h4000, 16'd128, 1'b0, 2'b10, 1, 1, 5, 4);
        repeat (3) @(negedge clk);
        #1;
        check(cmd_ready == 1'b0, "R10", "cmd_ready while busy", cmd_ready, 0);
        cmd_base = 32'h9000;
        cmd_corner0 = {16'd0, 16'd0};
        cmd_corner1 = {16'd2, 16'd2};
        cmd_valid = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        cmd_valid = 1'b0;
        wait_done(k);
        compare("R10", n);
    endtask

    initial begin
        t_reset();
        t_linear();
        t_tiled();
        t_stall();
        t_single();
        t_empty();
        t_small_bpp();
        t_busy_ignore();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule